// File: doc/BRIEF.md
# Character Display Line Formatter

This block builds the byte stream that fills one line of a character display. On a line-1 request it takes an 8-bit measurement and splits it into hundreds, tens and ones decimal digits. It then emits a cursor-home command followed by the text `Volts = H.TO V`. On a line-2 request it emits a second cursor-home command followed by the label `Key = `.

Each output byte travels with a register-select flag. The flag is low for a command and high for character data. Bytes are offered under a valid/ready handshake to a display-bus driver that sits downstream and handles the electrical timing of the display.

The fixed text comes from a small character table. A message ends at a zero entry in that table. The binary-to-decimal conversion is a shift-and-add-three loop of eight clocks that runs before the command byte is offered. After the last byte is taken, a one-clock done strobe is raised.

Top module: `lcd_line_fmt`

## Requirements
- R1: A line-1 request (`line_sel` = 0) first offers the byte 0x80 with `out_rs` = 0. Every later byte of that request has `out_rs` = 1.
- R2: A line-2 request (`line_sel` = 1) offers exactly seven bytes. The first is 0xC0 with `out_rs` = 0. The other six are the ASCII text `Key = ` with `out_rs` = 1.
- R3: A line-1 request offers exactly fifteen bytes. After the command byte come the ASCII text `Volts = `, the hundreds digit, `.` (0x2E), the tens digit, the ones digit, a space (0x20) and `V` (0x56).
- R4: The three digits are the decimal hundreds, tens and ones of the value, over the range 0 to 255. Each digit is sent as 0x30 plus the digit, and leading zeros are kept (value 7 gives `0.07`).
- R5: A start strobe that arrives while a request is in progress is ignored. In-progress means from the clock that accepts a start up to and including the clock that accepts the last byte. Such a strobe changes neither the current stream nor what follows it.
- R6: The zero entry that ends a message in the table is never offered. No byte offered with `out_rs` = 1 equals 0x00.
- R7: `done` is high for exactly one clock, the clock after the last byte of a request is accepted, and at no other time.
- R8: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_rs` hold their values and `out_valid` stays high. No byte is lost or repeated under backpressure.
- R9: A start strobe in the idle state samples `line_sel` and `value` on that clock. Later changes to those inputs do not affect the request.
- R10: The first byte of a request is offered on the ninth clock after the clock that accepts the start, once the eight conversion steps are done.
- R11: After reset `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| line_sel | input | 1 | 0 selects the voltage line, 1 the key label line |
| value | input | 8 | Binary measurement to format |
| out_byte | output | 8 | Byte offered to the display driver |
| out_rs | output | 1 | 0 for a command byte, 1 for character data |
| out_valid | output | 1 | `out_byte` and `out_rs` are offered |
| out_ready | input | 1 | Downstream takes the offered byte this clock |
| done | output | 1 | One-clock pulse after the last byte is accepted |

## Verification
Every clock, the assertions check the handshake hold under backpressure and that a command byte is only ever 0x80 or 0xC0. They also check that each stream opens with a command, that no zero byte is sent as data, and that `done` is a single pulse that follows an accepted byte. Only the bench scenarios can show the rest. These are the exact byte order of each line, the decimal digits for chosen values such as 0, 7, 99, 128 and 255, and the nine-clock start latency. They also show that a start strobe or input change during a request has no effect, with the expected stream compared byte by byte against a queue built from the requirements.

// File: rtl/lcd_line_fmt.sv
module lcd_line_fmt #(
  parameter logic [7:0] HOME_L1 = 8'h80,
  parameter logic [7:0] HOME_L2 = 8'hC0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       line_sel,
  input  logic [7:0] value,
  output logic [7:0] out_byte,
  output logic       out_rs,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       done
);
  localparam int          STEPS  = 8;
  localparam logic [7:0]  ASC0   = 8'h30;
  localparam logic [3:0]  L1_BASE = 4'd0;
  localparam logic [3:0]  L2_BASE = 4'd9;
  localparam logic [2:0]  TAIL_LAST = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_CONV, S_CMD, S_MSG, S_TAIL} st_t;

  st_t         st;
  logic        line_q;
  logic [19:0] conv;
  logic [2:0]  cnt;
  logic [3:0]  ptr;
  logic [2:0]  tix;
  logic [7:0]  tail_b;
  logic        take;

  function automatic logic [7:0] chr(input logic [3:0] a);
    case (a)
      4'd0:  chr = "V";
      4'd1:  chr = "o";
      4'd2:  chr = "l";
      4'd3:  chr = "t";
      4'd4:  chr = "s";
      4'd5:  chr = " ";
      4'd6:  chr = "=";
      4'd7:  chr = " ";
      4'd9:  chr = "K";
      4'd10: chr = "e";
      4'd11: chr = "y";
      4'd12: chr = " ";
      4'd13: chr = "=";
      4'd14: chr = " ";
      default: chr = 8'h00;
    endcase
  endfunction

  function automatic logic [19:0] dabble(input logic [19:0] x);
    logic [19:0] y;
    y = x;
    for (int i = 0; i < 3; i++)
      if (y[8+4*i +: 4] >= 4'd5) y[8+4*i +: 4] = y[8+4*i +: 4] + 4'd3;
    dabble = {y[18:0], 1'b0};
  endfunction

  assign take      = out_valid & out_ready;
  assign out_valid = (st == S_CMD) || (st == S_MSG) || (st == S_TAIL);
  assign out_rs    = (st != S_CMD);

  always_comb begin
    case (tix)
      3'd0:    tail_b = ASC0 + {4'd0, conv[19:16]};
      3'd1:    tail_b = ".";
      3'd2:    tail_b = ASC0 + {4'd0, conv[15:12]};
      3'd3:    tail_b = ASC0 + {4'd0, conv[11:8]};
      3'd4:    tail_b = " ";
      default: tail_b = "V";
    endcase
  end

  always_comb begin
    case (st)
      S_CMD:   out_byte = line_q ? HOME_L2 : HOME_L1;
      S_MSG:   out_byte = chr(ptr);
      S_TAIL:  out_byte = tail_b;
      default: out_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      line_q <= 1'b0;
      conv   <= '0;
      cnt    <= '0;
      ptr    <= '0;
      tix    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          line_q <= line_sel;
          conv   <= {12'd0, value};
          cnt    <= '0;
          st     <= S_CONV;
        end
        S_CONV: begin
          conv <= dabble(conv);
          cnt  <= cnt + 3'd1;
          if (cnt == 3'(STEPS - 1)) st <= S_CMD;
        end
        S_CMD: if (take) begin
          ptr <= line_q ? L2_BASE : L1_BASE;
          st  <= S_MSG;
        end
        S_MSG: if (take) begin
          ptr <= ptr + 4'd1;
          if (chr(ptr + 4'd1) == 8'h00) begin
            if (line_q) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              st  <= S_TAIL;
              tix <= '0;
            end
          end
        end
        S_TAIL: if (take) begin
          tix <= tix + 3'd1;
          if (tix == TAIL_LAST) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_line_fmt_chk.sv
module lcd_line_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       line_sel,
  input logic [7:0] value,
  input logic [7:0] out_byte,
  input logic       out_rs,
  input logic       out_valid,
  input logic       out_ready,
  input logic       done
);
  p_cmd_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_rs |-> (out_byte == 8'h80 || out_byte == 8'hC0));

  p_first_is_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !out_rs);

  p_no_nul_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_rs |-> out_byte != 8'h00);

  p_done_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_rs));
endmodule

bind lcd_line_fmt lcd_line_fmt_chk u_chk (.*);

// File: tb/lcd_line_fmt_bench.sv
`timescale 1ns/1ps
module lcd_line_fmt_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       start = 0;
  logic       line_sel = 0;
  logic [7:0] value = 0;
  logic [7:0] out_byte;
  logic       out_rs;
  logic       out_valid;
  logic       out_ready = 1;
  logic       done;

  int vectors = 0;
  int errors  = 0;
  logic [8:0] expq[$];
  bit pend_done = 0;
  bit prev_stall = 0;
  logic [8:0] prev_pair;
  bit bp_mode = 0;
  logic [7:0] lfsr = 8'h5A;
  bit mon_on = 0;

  always #4 clk = ~clk;

  lcd_line_fmt u_lcd_line_fmt (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= bp_mode ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      chk(done == pend_done, "R7 done timing", done, pend_done);
      pend_done = 0;
      if (prev_stall)
        chk(out_valid && {out_rs, out_byte} == prev_pair, "R8 hold", {out_valid, out_rs, out_byte}, {1'b1, prev_pair});
      prev_stall = out_valid && !out_ready;
      prev_pair = {out_rs, out_byte};
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(0, "R5 unexpected byte", {out_rs, out_byte}, 0);
        else begin
          logic [8:0] e;
          e = expq.pop_front();
          chk({out_rs, out_byte} == e, "R1 R2 R3 R4 byte", {out_rs, out_byte}, e);
          if (expq.size() == 0) pend_done = 1;
        end
      end
    end
  end

  task automatic push_str(input string s);
    for (int i = 0; i < s.len(); i++) expq.push_back({1'b1, s[i]});
  endtask

  task automatic request(input bit ln, input logic [7:0] v, input bit disturb);
    int n;
    int w;
    if (ln) begin
      expq.push_back({1'b0, 8'hC0});
      push_str("Key = ");
    end else begin
      expq.push_back({1'b0, 8'h80});
      push_str("Volts = ");
      expq.push_back({1'b1, 8'h30 + 8'(v / 100)});
      expq.push_back({1'b1, 8'h2E});
      expq.push_back({1'b1, 8'h30 + 8'((v / 10) % 10)});
      expq.push_back({1'b1, 8'h30 + 8'(v % 10)});
      expq.push_back({1'b1, 8'h20});
      expq.push_back({1'b1, 8'h56});
    end
    @(negedge clk);
    start <= 1; line_sel <= ln; value <= v;
    @(negedge clk);
    start <= 0;
    if (disturb) begin line_sel <= ~ln; value <= ~v; end
    n = 1;
    #1;
    while (!out_valid && n < 40) begin
      @(negedge clk); #1; n++;
    end
    chk(n == 9, "R10 latency", n, 9);
    if (disturb) begin
      @(negedge clk);
      start <= 1;
      @(negedge clk);
      start <= 0;
    end
    w = 0;
    while ((expq.size() != 0 || pend_done) && w < 400) begin
      @(negedge clk); w++;
    end
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R5 R9 stream complete", expq.size(), 0);
    chk(!out_valid, "R5 idle after request", out_valid, 0);
    expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid, "R11 reset valid", out_valid, 0);
    chk(!done, "R11 reset done", done, 0);
    @(negedge clk);
    rst_n <= 1;
    mon_on = 1;
    @(negedge clk);
    request(0, 8'd0,   0);
    request(0, 8'd255, 0);
    request(0, 8'd128, 0);
    request(0, 8'd7,   0);
    request(1, 8'd42,  0);
    bp_mode = 1;
    request(0, 8'd99,  0);
    request(1, 8'd0,   0);
    request(0, 8'd200, 1);
    bp_mode = 0;
    request(1, 8'd13,  1);
    request(0, 8'd64,  1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule